// File: doc/BRIEF.md
# Pipelined synchronous burst SRAM

A synthesizable behavioural model of a single-port synchronous static RAM with 32-bit words and four byte lanes. Address, control and write data are all captured on the rising clock edge. Read data passes through one output register, so a word appears one edge after the edge that registered its access. The usual tri-state data bus is split into a data-in bus, a data-out bus and an output-drive flag (`dout_en`). A low `dout_en` stands for a high-impedance bus.

An access starts on either of two address strobes. A processor strobe counts only while the chip enable is low. A controller strobe counts on any edge. When the strobe edge finds the chip selected, it loads a new base address. When it finds the chip unselected, it deselects the chip. After an access starts, a burst-advance input steps the two low address bits through four words. The step order comes from a small sequencer submodule: linear by default, and interleaved when `BURST_INTERLEAVED` is set. Writes are self-timed and commit on the edge that captures them. They come from a global write that covers every lane, or from per-lane selects gated by a lane-write enable. A sleep input freezes all state and the array. The array depth `DEPTH` is a parameter. A synchronous reset clears the selection and pipeline state but not the array.

Top module: `sync_burst_sram`

## Requirements
- R1: A read access registered on rising edge k drives its word on `dout` with `dout_en` high after edge k+1, when `out_en_n` is low and no write is requested.
- R2: The chip is selected when `en_n`=0, `sel_hi`=1 and `sel_lo_n`=0. A strobe edge (`cpu_strobe_n`=0 with `en_n`=0, or `ctl_strobe_n`=0) loads `addr` as the new base and restarts the burst if the chip is selected, and deselects the chip if it is not.
- R3: `cpu_strobe_n`=0 while `en_n`=1 has no effect: the burst in progress continues.
- R4: `wr_all_n`=0 on an edge of a selected access writes all four bytes, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R5: With `lane_wr_en_n`=0, each `lane_sel_n[i]`=0 writes `din[8i+7:8i]` and leaves the other bytes intact. With `lane_wr_en_n`=1, the lane selects write nothing.
- R6: `cpu_strobe_n`=0 on an edge blocks lane-select writes on that edge.
- R7: `dout_en` is low whenever `out_en_n`=1 or a write is requested on the inputs (`wr_all_n`=0, or `lane_wr_en_n`=0 with any `lane_sel_n` bit low). It responds to these inputs without waiting for a clock edge.
- R8: While `doze`=1, no edge changes the address, burst position, pipeline or array.
- R9: A deselecting strobe on edge k leaves the read of edge k-1 on the output after edge k, and `dout_en` is low after edge k+1.
- R10: `step_n`=0 on an edge advances the burst position by one, modulo 4. The low address bits are then (base+position) mod 4 in the default linear order. `step_n`=1 holds the position.
- R11: A read registered on the edge after a write to the same address returns the newly written data.
- R12: After reset, `dout_en` is low until a new read has gone through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset of selection and pipeline state, active low |
| doze | input | 1 | Sleep: freezes all state when high |
| en_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all four bytes, active low |
| lane_wr_en_n | input | 1 | Enable for the per-lane write selects, active low |
| lane_sel_n | input | 4 | Per-lane write selects, bit i covers din[8i+7:8i] |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | $clog2(DEPTH) | Word address |
| din | input | 32 | Write data |
| dout | output | 32 | Read data |
| dout_en | output | 1 | Output drive flag; low means high impedance |

## Verification
The bench first fills the array with bursts driven by the controller strobe and global write. It then reads bursts started from an unaligned base through each strobe, which tells a wrapping step order from a plain increment and shows the one-cycle read latency. Single writes follow, each read back on the very next edge. They combine the lane selects with the global write, the lane-write enable held high, and the processor strobe held low, so an override, a block and a partial merge each leave different data in the word. Further sequences cover a gated processor strobe in the middle of a burst, a deselecting strobe, output-enable and write-request pulses while data is on the bus, and a sleep window with advance and write held active. A long run of random inputs ends the bench.

// File: rtl/burst_order.sv
module burst_order #(
  parameter bit INTERLEAVED = 1'b0
) (
  input  logic [1:0] base,
  input  logic [1:0] step,
  output logic [1:0] lo
);
  generate
    if (INTERLEAVED) begin : g_xor
      assign lo = base ^ step;
    end else begin : g_add
      assign lo = base + step;
    end
  endgenerate
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int DEPTH = 256,
  parameter bit BURST_INTERLEAVED = 1'b0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          doze,
  input  logic          en_n,
  input  logic          sel_hi,
  input  logic          sel_lo_n,
  input  logic          cpu_strobe_n,
  input  logic          ctl_strobe_n,
  input  logic          step_n,
  input  logic          wr_all_n,
  input  logic          lane_wr_en_n,
  input  logic [3:0]    lane_sel_n,
  input  logic          out_en_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   din,
  output logic [31:0]   dout,
  output logic          dout_en
);
  localparam int LANES = 4;

  logic          sel_in, strobe, start, desel;
  logic [AW-1:0] base_q, base_nx, cur_q, acc_addr;
  logic [1:0]    step_q, step_nx, lo;
  logic          sel_q, sel_nx, rd_q, dval_q, wr_any, wr_req;
  logic [LANES-1:0] lane_we;

  assign sel_in  = !en_n && sel_hi && !sel_lo_n;
  assign strobe  = (!cpu_strobe_n && !en_n) || !ctl_strobe_n;
  assign start   = strobe && sel_in;
  assign desel   = strobe && !sel_in;

  assign base_nx = start ? addr : base_q;
  assign step_nx = start ? 2'd0 : (!step_n ? step_q + 2'd1 : step_q);
  assign sel_nx  = start ? 1'b1 : (desel ? 1'b0 : sel_q);

  burst_order #(.INTERLEAVED(BURST_INTERLEAVED)) u_order (
    .base(base_nx[1:0]),
    .step(step_nx),
    .lo  (lo)
  );

  assign acc_addr = {base_nx[AW-1:2], lo};
  assign wr_any   = |lane_we;
  assign wr_req   = !wr_all_n || (!lane_wr_en_n && !(&lane_sel_n));

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] mem [DEPTH];
      logic [7:0] q;
      assign lane_we[i] = sel_nx &&
        (!wr_all_n || (!lane_wr_en_n && cpu_strobe_n && !lane_sel_n[i]));
      always_ff @(posedge clk) begin
        if (!doze) begin
          if (lane_we[i]) mem[acc_addr] <= din[8*i +: 8];
          q <= mem[cur_q];
        end
      end
      assign dout[8*i +: 8] = q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      cur_q  <= '0;
      sel_q  <= 1'b0;
      rd_q   <= 1'b0;
      dval_q <= 1'b0;
    end else if (!doze) begin
      base_q <= base_nx;
      step_q <= step_nx;
      cur_q  <= acc_addr;
      sel_q  <= sel_nx;
      rd_q   <= sel_nx && !wr_any;
      dval_q <= rd_q;
    end
  end

  assign dout_en = !out_en_n && dval_q && !wr_req;

  a_r1_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dval_q) |-> $past(rd_q));
  a_r7_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dout_en);
  a_r7_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_all_n |-> !dout_en);
  a_r8_doze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    doze |=> $stable(cur_q) && $stable(step_q) && $stable(dval_q));
  a_r9_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (desel && !doze) ##1 !doze |=> !dval_q);
endmodule

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0, doze = 0;
  logic en_n = 1, sel_hi = 0, sel_lo_n = 1;
  logic cpu_strobe_n = 1, ctl_strobe_n = 1, step_n = 1;
  logic wr_all_n = 1, lane_wr_en_n = 1, out_en_n = 0;
  logic [3:0] lane_sel_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic dout_en;

  int checks = 0, fails = 0;
  string tag = "R12";
  bit done = 0;

  sync_burst_sram #(.DEPTH(DEPTH)) i_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .doze(doze), .en_n(en_n), .sel_hi(sel_hi),
    .sel_lo_n(sel_lo_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .step_n(step_n), .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en));

  always #2.5 clk = ~clk;

  // Behavioural reference model
  logic [31:0] mm [DEPTH];
  int m_base = 0, m_step = 0, m_pa = 0, a;
  bit m_sel = 0, m_pend = 0, m_dval = 0, s_in, stb;
  logic [31:0] m_data = '0;
  logic [3:0] lanes;

  initial for (int k = 0; k < DEPTH; k++) mm[k] = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_pend = 0; m_dval = 0; m_step = 0;
    end else if (!doze) begin
      s_in = !en_n && sel_hi && !sel_lo_n;
      stb  = (!cpu_strobe_n && !en_n) || !ctl_strobe_n;
      if (stb && s_in) begin
        m_base = int'(addr); m_step = 0; m_sel = 1;
      end else begin
        if (stb) m_sel = 0;
        if (!step_n) m_step = (m_step + 1) % 4;
      end
      a = (m_base & ~3) | ((m_base + m_step) & 3);
      if (!wr_all_n) lanes = 4'hF;
      else if (!lane_wr_en_n && cpu_strobe_n) lanes = ~lane_sel_n;
      else lanes = 4'h0;
      if (!m_sel) lanes = 4'h0;
      m_dval = m_pend;
      if (m_pend) m_data = mm[m_pa];
      for (int k = 0; k < 4; k++) if (lanes[k]) mm[a][8*k +: 8] = din[8*k +: 8];
      m_pend = m_sel && (lanes == 4'h0);
      m_pa = a;
    end
  end

  task automatic cmp();
    bit exp_en;
    exp_en = !out_en_n && m_dval &&
             !(!wr_all_n || (!lane_wr_en_n && lane_sel_n != 4'hF));
    checks++;
    if (dout_en !== exp_en) begin
      fails++;
      $display("FAIL %s dout_en actual=%b expected=%b at %0t", tag, dout_en, exp_en, $time);
    end else if (exp_en) begin
      checks++;
      if (dout !== m_data) begin
        fails++;
        $display("FAIL %s dout actual=%h expected=%h at %0t", tag, dout, m_data, $time);
      end
    end
  endtask

  task automatic tick();
    #1 cmp();
    @(negedge clk);
  endtask

  task automatic idle();
    en_n = 1; sel_hi = 0; sel_lo_n = 1; cpu_strobe_n = 1; ctl_strobe_n = 1;
    step_n = 1; wr_all_n = 1; lane_wr_en_n = 1; lane_sel_n = 4'hF;
    out_en_n = 0; doze = 0;
  endtask

  task automatic select();
    en_n = 0; sel_hi = 1; sel_lo_n = 0;
  endtask

  task automatic wr_burst(input int base, input logic [31:0] d0);
    idle(); select(); ctl_strobe_n = 0; addr = AW'(base); wr_all_n = 0; din = d0;
    tick();
    ctl_strobe_n = 1; step_n = 0;
    for (int k = 1; k < 4; k++) begin din = d0 + 32'(k); tick(); end
    idle();
  endtask

  task automatic rd_burst(input int base, input bit use_cpu);
    idle(); select(); addr = AW'(base);
    if (use_cpu) cpu_strobe_n = 0; else ctl_strobe_n = 0;
    tick();
    cpu_strobe_n = 1; ctl_strobe_n = 1; step_n = 0;
    repeat (3) tick();
    idle(); tick(); tick();
  endtask

  task automatic one_write(input int ad, input logic [31:0] d, input bit gw,
                           input bit lwe, input logic [3:0] ls, input bit via_cpu);
    idle(); select(); addr = AW'(ad); din = d;
    if (via_cpu) cpu_strobe_n = 0; else ctl_strobe_n = 0;
    wr_all_n = !gw; lane_wr_en_n = !lwe; lane_sel_n = ls;
    tick();
    // R11: read of the same address starts on the very next edge
    idle(); select(); ctl_strobe_n = 0; addr = AW'(ad);
    tick();
    idle(); tick(); tick();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in %s", tag);
      summary();
      $finish;
    end
  end

  initial begin
    idle(); rst_n = 0;
    @(negedge clk);
    tag = "R12";
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    tag = "R4_fill";
    for (int b = 0; b < DEPTH / 4; b++) wr_burst(b * 4, 32'h9E370000 ^ 32'(b << 8));

    tag = "R10";
    rd_burst(6'h12, 1'b1);
    rd_burst(6'h23, 1'b0);
    tag = "R1";
    rd_burst(6'h08, 1'b0);

    tag = "R5";
    one_write(5, 32'h11223344, 0, 1, 4'b1010, 0);
    tag = "R4";
    one_write(6, 32'hCAFEF00D, 1, 1, 4'b1110, 0);
    tag = "R5_blocked";
    one_write(7, 32'hDEADBEEF, 0, 0, 4'b0000, 0);
    tag = "R6";
    one_write(9, 32'h0BADC0DE, 0, 1, 4'b0000, 1);
    tag = "R11";
    one_write(10, 32'h5A5A1234, 1, 0, 4'hF, 0);

    tag = "R3";
    idle(); select(); ctl_strobe_n = 0; addr = 6'h20; tick();
    idle(); en_n = 1; cpu_strobe_n = 0; addr = 6'h30; step_n = 0; tick();
    cpu_strobe_n = 1; tick(); tick();
    idle(); tick(); tick();

    tag = "R9";
    idle(); select(); ctl_strobe_n = 0; addr = 6'h24; tick();
    idle(); tick(); tick();
    en_n = 0; sel_hi = 0; ctl_strobe_n = 0; tick();
    idle(); tick(); tick(); tick();

    tag = "R7";
    idle(); select(); ctl_strobe_n = 0; addr = 6'h28; tick();
    idle(); step_n = 0; tick();
    out_en_n = 1; tick();
    out_en_n = 0; tick();
    step_n = 1; lane_wr_en_n = 0; lane_sel_n = 4'b1011; tick();
    idle(); tick(); tick();

    tag = "R8";
    idle(); select(); ctl_strobe_n = 0; addr = 6'h2C; tick();
    idle(); step_n = 0; tick();
    doze = 1; wr_all_n = 0; din = 32'hFFFF0000; repeat (3) tick();
    doze = 0; wr_all_n = 1; tick(); tick();
    idle(); tick(); tick();
    rd_burst(6'h2C, 1'b0);

    tag = "R2";
    for (int n = 0; n < 600; n++) begin
      en_n = ($urandom % 4) == 0;
      sel_hi = ($urandom % 6) != 0;
      sel_lo_n = ($urandom % 6) == 0;
      cpu_strobe_n = ($urandom % 5) != 0;
      ctl_strobe_n = ($urandom % 4) != 0;
      step_n = ($urandom % 2) == 0;
      wr_all_n = ($urandom % 6) != 0;
      lane_wr_en_n = ($urandom % 4) != 0;
      lane_sel_n = 4'($urandom);
      out_en_n = ($urandom % 8) == 0;
      doze = ($urandom % 12) == 0;
      addr = AW'($urandom);
      din = $urandom;
      tick();
    end
    idle(); repeat (3) tick();

    done = 1;
    summary();
    $finish;
  end
endmodule